// File: doc/BRIEF.md
# Registered Accumulator ALU with Zero Flag

This block is the arithmetic stage of a small accumulator datapath. On each rising clock edge it samples an accumulator operand, a data operand and a three-bit operation code. It then stores the selected result in an output register. Both operands and the result are two's-complement words, eight bits wide by default. Sums and differences wrap modulo 2^W, and no carry or overflow is reported.

The zero flag does not come from the result register. It is a purely combinational view of the accumulator input. Surrounding control logic can therefore test the current accumulator in the same cycle it is presented, before any operation has been registered. A synchronous, active-high reset clears the result register and leaves the zero flag alone.

Top module: `accum_alu`

## Requirements
- R1: When `rst` is 1 at a rising edge of `clk`, `res_o` becomes 0 after that edge, whatever the operands and opcode are.
- R2: Opcode 3'b000 registers the accumulator operand unchanged.
- R3: Opcode 3'b001 registers (accumulator + data) mod 2^W, and the carry is dropped.
- R4: Opcode 3'b010 registers (accumulator - data) mod 2^W.
- R5: Opcode 3'b011 registers the bitwise AND of the two operands.
- R6: Opcode 3'b100 registers the bitwise XOR of the two operands.
- R7: Opcode 3'b101 registers the absolute value of the accumulator, with bit W-1 taken as the sign. The most negative value (0x80 at W=8) gives back 0x80.
- R8: Opcode 3'b110 registers the two's-complement negation of the accumulator. The most negative value negates to itself.
- R9: Opcode 3'b111 registers the data operand unchanged.
- R10: `zero_o` is 1 exactly when `acc_i` is all zeros. It follows `acc_i` within the same cycle, with no clock edge needed, and reset does not affect it.
- R11: `res_o` changes only at a rising clock edge. Changes to the operands or the opcode between edges leave it unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; sampling and register update on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_i | input | W (8) | Accumulator operand, two's complement |
| dat_i | input | W (8) | Data operand, two's complement |
| op_i | input | 3 | Operation select |
| res_o | output | W (8) | Registered result |
| zero_o | output | 1 | Combinational flag: accumulator input equals zero |

## Verification
The zero flag and the result register can both act in the same cycle, either together with reset or with a new registered result. The bench presents a zero accumulator while reset is held. It then checks that the flag reads 1 while the register clears, and that the flag drops as soon as the accumulator turns nonzero, still inside reset. Between edges, it also changes the operands and the opcode after a result has been registered. It then checks that the flag tracks the new accumulator at once while `res_o` holds the previous result until the next edge.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OPC_KEEP_ACC = 3'b000,
    OPC_SUM      = 3'b001,
    OPC_DIFF     = 3'b010,
    OPC_MASK     = 3'b011,
    OPC_TOGGLE   = 3'b100,
    OPC_MAGN     = 3'b101,
    OPC_INVERT   = 3'b110,
    OPC_TAKE_DAT = 3'b111
  } alu_op_t;

  // Opcode belongs to the two-operand adder path
  function automatic logic is_adder_op(input alu_op_t op);
    return (op == OPC_SUM) || (op == OPC_DIFF);
  endfunction

  // Adder needs inverted data plus carry-in
  function automatic logic is_subtract(input alu_op_t op);
    return op == OPC_DIFF;
  endfunction

endpackage

// File: rtl/aalu_adder.sv
module aalu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o
);
  // Subtract as a + ~b + 1; the carry out of the top bit is discarded
  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] x,
                                            input logic [W-1:0] y,
                                            input logic         cin);
    return x + y + W'(cin);
  endfunction

  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum_o = wrap_add(a_i, b_eff, sub_i);
  end
endmodule

// File: rtl/aalu_unary.sv
module aalu_unary #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] neg_o,
  output logic [W-1:0] abs_o,
  output logic         sign_o
);
  function automatic logic [W-1:0] twos_neg(input logic [W-1:0] x);
    return (~x) + W'(1);
  endfunction

  assign sign_o = a_i[W-1];
  assign neg_o  = twos_neg(a_i);
  assign abs_o  = sign_o ? neg_o : a_i;
endmodule

// File: rtl/aalu_bitwise.sv
module aalu_bitwise #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] xor_o
);
  for (genvar i = 0; i < W; i++) begin : g_slice
    assign and_o[i] = a_i[i] & b_i[i];
    assign xor_o[i] = a_i[i] ^ b_i[i];
  end
endmodule

// File: rtl/aalu_zero_det.sv
module aalu_zero_det #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  output logic         zero_o
);
  assign zero_o = ~(|a_i);
endmodule

// File: rtl/accum_alu.sv
module accum_alu #(
  parameter int W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [W-1:0]                   acc_i,
  input  logic [W-1:0]                   dat_i,
  input  logic [accum_alu_pkg::OP_W-1:0] op_i,
  output logic [W-1:0]                   res_o,
  output logic                           zero_o
);
  import accum_alu_pkg::*;

  alu_op_t      op;
  logic [W-1:0] sum_w, neg_w, abs_w, and_w, xor_w;
  logic         acc_sign;
  logic [W-1:0] nxt_res;

  assign op = alu_op_t'(op_i);

  aalu_adder #(.W(W)) adder_i (
    .a_i(acc_i), .b_i(dat_i), .sub_i(is_subtract(op)), .sum_o(sum_w)
  );

  aalu_unary #(.W(W)) unary_i (
    .a_i(acc_i), .neg_o(neg_w), .abs_o(abs_w), .sign_o(acc_sign)
  );

  aalu_bitwise #(.W(W)) bitw_i (
    .a_i(acc_i), .b_i(dat_i), .and_o(and_w), .xor_o(xor_w)
  );

  aalu_zero_det #(.W(W)) zdet_i (
    .a_i(acc_i), .zero_o(zero_o)
  );

  // Result select; an undefined opcode falls to the default and yields zero
  always_comb begin
    case (op)
      OPC_KEEP_ACC: nxt_res = acc_i;
      OPC_SUM,
      OPC_DIFF:     nxt_res = sum_w;
      OPC_MASK:     nxt_res = and_w;
      OPC_TOGGLE:   nxt_res = xor_w;
      OPC_MAGN:     nxt_res = abs_w;
      OPC_INVERT:   nxt_res = neg_w;
      OPC_TAKE_DAT: nxt_res = dat_i;
      default:      nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) res_o <= '0;
    else     res_o <= nxt_res;
  end
endmodule

// File: rtl/accum_alu_chk.sv
module accum_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] acc_i,
  input logic [W-1:0] dat_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] res_o,
  input logic         zero_o,
  input logic [W-1:0] nxt_res
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic rst_seen = 1'b0;
  always @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen) AST_RESET_CLEARS: assert (res_o == '0); // R1
    AST_ZERO_TRACKS: assert (zero_o == (acc_i == '0)); // R10
  end

  AST_SUM_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (!rst && op_i == 3'b001) |=> res_o == W'($past(acc_i) + $past(dat_i))); // R3
  AST_DIFF_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (!rst && op_i == 3'b010) |=> res_o == W'($past(acc_i) - $past(dat_i))); // R4
  AST_MAGN_NONNEG: assert property (@(posedge clk) disable iff (rst)
    (!rst && op_i == 3'b101 && acc_i != MOST_NEG) |=> !res_o[W-1]); // R7
  AST_INVERT_SUMS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!rst && op_i == 3'b110) |=> W'(res_o + $past(acc_i)) == '0); // R8
  AST_TAKE_DATA: assert property (@(posedge clk) disable iff (rst)
    (!rst && op_i == 3'b111) |=> res_o == $past(dat_i)); // R9
  AST_SELECT_LANDS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> res_o == $past(nxt_res)); // R11
endmodule

bind accum_alu accum_alu_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .acc_i(acc_i), .dat_i(dat_i), .op_i(op_i),
  .res_o(res_o), .zero_o(zero_o), .nxt_res(nxt_res)
);

// File: tb/accum_alu_tb_top.sv
`timescale 1ns/1ps
module accum_alu_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] acc = '0;
  logic [W-1:0] dat = '0;
  logic [2:0]   op  = '0;
  logic [W-1:0] res;
  logic         zero;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  accum_alu #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .acc_i(acc), .dat_i(dat), .op_i(op),
    .res_o(res), .zero_o(zero)
  );

  function automatic int model(int o, int a, int d);
    int sa;
    sa = (a >= 128) ? a - 256 : a;
    case (o)
      0: return a;
      1: return (a + d) % 256;
      2: return (a - d + 256) % 256;
      3: return a & d;
      4: return a ^ d;
      5: return ((sa < 0) ? -sa : sa) % 256;
      6: return (256 - a) % 256;
      default: return d;
    endcase
  endfunction

  function automatic string req_of(int o);
    case (o)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R7"; 6: return "R8"; default: return "R9";
    endcase
  endfunction

  function automatic int data_pick(int j);
    case (j)
      0: return 0; 1: return 1; 2: return 8'h7F; 3: return 8'h80;
      4: return 8'hFF; default: return (j * 37 + 3) % 256;
    endcase
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    op = 3'b001; acc = 8'h12; dat = 8'h34;
    @(posedge clk); #2;
    check("R1", res, 0);

    // R10 with R1: zero flag live while reset clears the register
    @(negedge clk); acc = 8'h00; dat = 8'h05;
    #1 check("R10", zero, 1);
    @(posedge clk); #2;
    check("R1", res, 0);
    acc = 8'h03;
    #1 check("R10", zero, 0);
    check("R1", res, 0);

    @(negedge clk); rst = 1'b0;

    // Sweep every opcode against every accumulator value
    for (int o = 0; o < 8; o++) begin
      for (int a = 0; a < 256; a++) begin
        for (int j = 0; j < 16; j++) begin
          @(negedge clk);
          op = 3'(o); acc = 8'(a); dat = 8'(data_pick(j));
          #1 check("R10", zero, (a == 0) ? 1 : 0);
          @(posedge clk); #2;
          check(req_of(o), res, model(o, a, data_pick(j)));
        end
      end
    end

    // R7 / R8 corner: most negative accumulator
    @(negedge clk); op = 3'b101; acc = 8'h80;
    @(posedge clk); #2 check("R7", res, 8'h80);
    @(negedge clk); op = 3'b110; acc = 8'h80;
    @(posedge clk); #2 check("R8", res, 8'h80);

    // R11: mid-cycle changes do not reach the register before the edge
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); op = 3'b001; acc = 8'(k * 29 + 1); dat = 8'(k * 11);
      @(posedge clk); #2;
      op = 3'(k); acc = (k % 2 == 0) ? 8'h00 : 8'(k * 5 + 1); dat = 8'hA5;
      #3 check("R11", res, model(1, k * 29 + 1, k * 11));
      check("R10", zero, (k % 2 == 0) ? 1 : 0);
      @(posedge clk); #2;
      check(req_of(k), res, model(k, (k % 2 == 0) ? 0 : k * 5 + 1, 8'hA5));
    end

    // R1 mid-run: reset overrides a pending operation
    @(negedge clk); rst = 1'b1; op = 3'b111; dat = 8'h5A;
    @(posedge clk); #2 check("R1", res, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2 check("R9", res, 8'h5A);

    finish_run();
  end
endmodule